// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block produces the transmit gate vector of one egress port for eight traffic classes. Software loads a short list of schedule entries, each pairing an 8-bit gate mask with a duration counted in local ticks. It also loads the number of entries in use. Once the enable input rises, the block applies the masks one after the other and returns to the first entry after the last, so the list repeats forever.

Timing comes only from a local prescaler that divides the clock down to one tick, which is 1 us at the default setting. No base time is taken into account, and the first entry starts at once when the block is enabled. A one-cycle event pulse marks every point where a new entry takes effect. While the block is disabled, or when the entry count is zero, every gate is held open. The schedule can be written only while the block is disabled.

Top module: `egress_gate_sched`

## Requirements
- R1: After reset, `gate_open` is 8'hFF, `gate_event` is 0 and the entry count is 0.
- R2: While `enable` is low, or the entry count is zero, `gate_open` is 8'hFF and `gate_event` stays low.
- R3: On the first clock edge that samples `enable` high with a nonzero count, entry 0 takes effect. Its mask is on `gate_open` and `gate_event` is high in the cycle that follows, with no wait for any start time.
- R4: Bit n of a mask opens traffic class n. An entry with interval N ticks stays applied for exactly N*TICK_DIV clock cycles. An entry is written with `wr_is_count`=0 and `wr_idx` selecting the entry; `wr_data[27:20]` holds the mask and `wr_data[19:0]` holds the interval.
- R5: After the last entry (index count-1), execution returns to entry 0, and the wrap raises `gate_event` like any other boundary.
- R6: `gate_event` is high for exactly one cycle at each entry boundary and low at all other times.
- R7: A write made while `enable` is high, whether to an entry or to the count, has no effect.
- R8: An entry whose interval field is 0 lasts one tick.
- R9: The count is written with `wr_is_count`=1 from `wr_data[4:0]`. A value above 16 is stored as 16.
- R10: Lowering `enable` opens all gates from the next cycle. Raising it again restarts the schedule at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the schedule while high |
| wr_en | input | 1 | Write strobe, honoured only while disabled |
| wr_is_count | input | 1 | 1: write the entry count; 0: write an entry |
| wr_idx | input | 4 | Entry index for an entry write |
| wr_data | input | 28 | {mask[7:0], interval[19:0]}, or the count in bits [4:0] |
| gate_open | output | 8 | Gate open per traffic class |
| gate_event | output | 1 | One-cycle pulse at each entry boundary |

## Verification
Results are due on a fixed cycle schedule. Entry 0 and its pulse appear in the cycle after the edge that samples `enable` high. Each later boundary follows exactly interval*TICK_DIV cycles after the previous one. Disabling opens all gates in the cycle after the edge. The bench drives inputs on falling edges and samples on falling edges. It checks the boundary cycle itself and also the last cycle of each entry, so a boundary that arrives one cycle early or one cycle late makes a check fail.

// File: rtl/egress_gate_sched.sv
module egress_gate_sched #(
  parameter int N_TC        = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int IVAL_W      = 20,
  parameter int TICK_DIV    = 250,
  localparam int IDX_W  = $clog2(MAX_ENTRIES),
  localparam int CNT_W  = $clog2(MAX_ENTRIES + 1),
  localparam int DATA_W = N_TC + IVAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic              wr_is_count,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_TC-1:0]   gate_open,
  output logic              gate_event
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DATA_W-1:0] tbl [MAX_ENTRIES];
  logic [CNT_W-1:0]  cnt_q;
  logic              active;
  logic [IDX_W-1:0]  idx, nxt, last;
  logic [IVAL_W-1:0] left;
  logic [PW-1:0]     presc;
  logic [N_TC-1:0]   gate_q;
  logic              ev_q;
  logic              wr_ok;

  assign wr_ok      = wr_en && !enable;
  assign last       = IDX_W'(cnt_q - CNT_W'(1));
  assign nxt        = (idx == last) ? '0 : idx + IDX_W'(1);
  assign gate_open  = active ? gate_q : '1;
  assign gate_event = ev_q;

  function automatic logic [IVAL_W-1:0] ival_of(input logic [DATA_W-1:0] e);
    return (e[IVAL_W-1:0] == '0) ? IVAL_W'(1) : e[IVAL_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok && !wr_is_count) tbl[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_ok && wr_is_count)
      cnt_q <= (wr_data[CNT_W-1:0] > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES)
                                                          : wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      left   <= '0;
      presc  <= '0;
      gate_q <= '1;
      ev_q   <= 1'b0;
    end else begin
      ev_q <= 1'b0;
      if (!enable || cnt_q == '0) begin
        active <= 1'b0;
      end else if (!active) begin
        active <= 1'b1;
        idx    <= '0;
        left   <= ival_of(tbl[0]);
        presc  <= '0;
        gate_q <= tbl[0][DATA_W-1:IVAL_W];
        ev_q   <= 1'b1;
      end else if (presc == PW'(TICK_DIV - 1)) begin
        presc <= '0;
        if (left == IVAL_W'(1)) begin
          idx    <= nxt;
          left   <= ival_of(tbl[nxt]);
          gate_q <= tbl[nxt][DATA_W-1:IVAL_W];
          ev_q   <= 1'b1;
        end else begin
          left <= left - IVAL_W'(1);
        end
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end
endmodule

module egress_gate_sched_chk #(
  parameter int N_TC     = 8,
  parameter int CNT_W    = 5,
  parameter int TICK_DIV = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [N_TC-1:0]  gate_open,
  input logic             gate_event,
  input logic             active,
  input logic [CNT_W-1:0] cnt_q
);
  assert_closed_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate_open == '1 && !gate_event));

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> gate_event);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1 && gate_event) |=> !gate_event);

  assert_event_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_event |-> (active && $past(enable)));

  assert_no_write_when_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(cnt_q));
endmodule

bind egress_gate_sched egress_gate_sched_chk #(
  .N_TC(N_TC), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gate_open(gate_open),
  .gate_event(gate_event), .active(active), .cnt_q(cnt_q)
);

// File: tb/sim_egress_gate_sched.sv
module sim_egress_gate_sched;
  localparam int D = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_is_count = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [27:0] wr_data = '0;
  logic [7:0]  gate_open;
  logic        gate_event;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  egress_gate_sched #(.TICK_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_is_count(wr_is_count), .wr_idx(wr_idx), .wr_data(wr_data),
    .gate_open(gate_open), .gate_event(gate_event)
  );

  task automatic expect_out(input string req, input logic [7:0] g, input logic ev);
    checks++;
    if (gate_open !== g || gate_event !== ev) begin
      errors++;
      $display("FAIL %s: gate=%h ev=%b expected gate=%h ev=%b at %0t",
               req, gate_open, gate_event, g, ev, $time);
    end
  endtask

  task automatic wr_entry(input int i, input logic [7:0] m, input int iv);
    wr_en = 1'b1; wr_is_count = 1'b0; wr_idx = 4'(i); wr_data = {m, 20'(iv)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_count(input int c);
    wr_en = 1'b1; wr_is_count = 1'b1; wr_data = 28'(c);
    @(negedge clk);
    wr_en = 1'b0; wr_is_count = 1'b0;
  endtask

  task automatic run_entry(input string req, input logic [7:0] m, input int ticks);
    @(negedge clk);
    expect_out(req, m, 1'b1);
    repeat (ticks * D - 2) @(negedge clk);
    @(negedge clk);
    expect_out(req, m, 1'b0);
  endtask

  task automatic stop_sched(input string req);
    enable = 1'b0;
    @(negedge clk);
    expect_out(req, 8'hFF, 1'b0);
  endtask

  task automatic t_reset;
    expect_out("R1", 8'hFF, 1'b0);
  endtask

  task automatic t_zero_count;
    enable = 1'b1;
    repeat (3 * D) @(negedge clk);
    expect_out("R2 zero count", 8'hFF, 1'b0);
    stop_sched("R2 disabled");
  endtask

  task automatic t_basic;
    wr_entry(0, 8'h80, 2);
    wr_entry(1, 8'h7F, 3);
    wr_count(2);
    enable = 1'b1;
    run_entry("R3 R4 entry0", 8'h80, 2);
    run_entry("R4 entry1", 8'h7F, 3);
    run_entry("R5 wrap", 8'h80, 2);
    run_entry("R5 second cycle", 8'h7F, 3);
    @(negedge clk);
    expect_out("R6 boundary", 8'h80, 1'b1);
    @(negedge clk);
    expect_out("R6 one cycle", 8'h80, 1'b0);
    stop_sched("R10 disable");
  endtask

  task automatic t_write_ignored;
    enable = 1'b1;
    wr_en = 1'b1; wr_is_count = 1'b0; wr_idx = 4'd0; wr_data = {8'h01, 20'd1};
    @(negedge clk);
    wr_en = 1'b0;
    expect_out("R7 entry write", 8'h80, 1'b1);
    wr_count(1);
    repeat (2 * D - 1) @(negedge clk);
    expect_out("R7 count write", 8'h7F, 1'b1);
    repeat (D) @(negedge clk);
    stop_sched("R10 disable mid entry");
    enable = 1'b1;
    @(negedge clk);
    expect_out("R10 restart at 0", 8'h80, 1'b1);
    stop_sched("R10");
  endtask

  task automatic t_zero_ival;
    wr_entry(0, 8'h01, 0);
    wr_entry(1, 8'h02, 1);
    enable = 1'b1;
    run_entry("R8 zero interval", 8'h01, 1);
    run_entry("R8 next", 8'h02, 1);
    run_entry("R8 wrap", 8'h01, 1);
    stop_sched("R2");
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 16; i++) wr_entry(i, 8'(i + 1), 1);
    wr_count(31);
    enable = 1'b1;
    for (int i = 0; i < 16; i++) run_entry("R9 entry", 8'(i + 1), 1);
    run_entry("R9 wrap after 16", 8'h01, 1);
    stop_sched("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_basic();
    t_write_ignored();
    t_zero_ival();
    t_clamp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule